// File: doc/BRIEF.md
# Page-mode pseudo-SRAM controller

This block sits between an on-chip requester and an external 1M x 16 pseudo-SRAM whose array is built from self-refreshing dynamic cells. The requester presents one word access at a time on a valid/ready port: a direction flag, a 20-bit word address, 16 bits of write data and one enable bit per byte lane. The controller turns each request into the asynchronous strobe sequence the memory expects. It drives active-low chip select, output enable, write enable, two byte strobes and a power-down pin. The data bus is split into an outgoing value, a drive enable and a captured incoming value, so that the pad ring can build the tri-state buffer.

The memory groups words into pages of four. The upper 18 address bits name the page and the lower 2 bits name the word inside it. When a new request keeps the same direction, stays in the same page and follows an access with chip select still low, the controller issues a short page cycle instead of a full random cycle. Every other request first releases chip select and then runs a full random cycle. Page cycles may only run back to back for a bounded time, because the memory refreshes itself during ordinary cycles. A counter therefore forces chip select high before that bound is reached. After reset, the controller holds the memory deselected for a power-up interval before it accepts any request. All durations are parameters counted in clock cycles.

Top module: `psram_page_ctrl`

## Requirements
- R1: From reset until at least PWRUP_CYC clock cycles have passed, `req_ready` is low and `mem_cs_n` is high. `mem_pd_n` is high at all times.
- R2: A read accepted while no page is open (chip select high) runs a random cycle. `rsp_valid` rises exactly T_RAND_CYC cycles after the accepting edge. For the whole cycle `mem_cs_n` and `mem_oe_n` are low and `mem_we_n` is high.
- R3: Byte-enable bit 1 selects bits 15..8 through `mem_ub_n`, and bit 0 selects bits 7..0 through `mem_lb_n`. A strobe is low during an access only when its lane is enabled. Read data in a lane that is not enabled is returned as zero.
- R4: `mem_we_n` is low only while `mem_cs_n` is low, `mem_oe_n` is high and the bus is driven. Only the enabled lanes of the word change, and a later read returns the merged value.
- R5: A read that follows a read in the same page (address bits 19..2 equal), with no forced close between them, keeps `mem_cs_n` low without a break. Its `rsp_valid` comes T_PRE_CYC + T_PREAD_CYC cycles after acceptance, and the address holds steady during each access.
- R6: A write that follows a write in the same page keeps `mem_cs_n` low without a break and uses a cycle of T_PRE_CYC + T_PWRITE_CYC clocks.
- R7: A request that changes page or direction while a page is open first raises `mem_cs_n` for exactly T_PRE_CYC cycles and then runs a random cycle. For a read, `rsp_valid` comes T_PRE_CYC + T_RAND_CYC cycles after acceptance.
- R8: Once chip select has been held low through page activity for BURST_CYC cycles, the controller raises `mem_cs_n` before it accepts anything else. The next access is then a random cycle, so an unbroken low period never exceeds BURST_CYC plus a few access lengths.
- R9: `mem_dq_oe` is high only during a write access, and only when `mem_oe_n` is high in that cycle and was high in the cycle before.
- R10: Each read produces exactly one single-cycle `rsp_valid` pulse, and writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller takes the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address; bits 19..2 page, 1..0 word |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables: bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 20 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_pd_n | output | 1 | Power-down, active low (held inactive) |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data sampled from the memory |

## Verification
The forced close is the hardest case to reach from the ports. It needs chip select to stay low through page traffic for longer than the burst limit, and only an unbroken run of same-page, same-direction requests issued as soon as the controller is ready can do that. The bench shrinks the limit through its parameter and streams more than twenty same-page reads. It watches for a read whose latency jumps to the random-cycle value, and it measures the longest low period of chip select against the bound. Direction changes and page misses are aimed for directly. Seeded random traffic over a few pages then mixes all three cycle kinds.

// File: rtl/psram_pkg.sv
// Shared constants and types for the pseudo-SRAM page controller.
// Assumes a word-addressed memory with 8-bit byte lanes and power-of-two pages.
package psram_pkg;
    localparam int PS_AW    = 20;               // word address width
    localparam int PS_DW    = 16;               // data width
    localparam int PS_WPP   = 4;                // words per page
    localparam int PS_OFS   = $clog2(PS_WPP);   // in-page offset bits
    localparam int PS_NLANE = PS_DW / 8;        // byte lanes

    typedef enum logic [2:0] {
        S_PWRUP,   // power-up hold, chip deselected
        S_IDLE,    // chip deselected, no open page
        S_OPEN,    // chip selected between accesses, page open
        S_GAP,     // chip deselected for precharge before a random cycle
        S_ACC      // access in progress
    } seq_state_t;

    typedef struct packed {
        logic                wr;
        logic [PS_AW-1:0]    addr;
        logic [PS_DW-1:0]    wdata;
        logic [PS_NLANE-1:0] be;
    } psram_req_t;
endpackage

// File: rtl/psram_pwrup_timer.sv
// Counts the power-up hold after reset and then raises hold_done for good.
// Assumes HOLD_CYC >= 1; the counter stops once the hold has elapsed.
module psram_pwrup_timer #(
    parameter int HOLD_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic hold_done
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    logic [CW-1:0] cnt;

    // Advance the hold counter until the programmed interval has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            hold_done <= 1'b0;
        end else if (!hold_done) begin
            if (cnt == CW'(HOLD_CYC - 1)) hold_done <= 1'b1;
            cnt <= cnt + CW'(1);
        end
    end

    // R1
    hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |=> hold_done);
endmodule

// File: rtl/psram_burst_guard.sv
// Measures how long chip select has been held low by page activity.
// Assumes run is low during random cycles and deselected time; saturates at the limit.
module psram_burst_guard #(
    parameter int LIMIT_CYC = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic limit_hit
);
    localparam int CW = $clog2(LIMIT_CYC + 1);

    logic [CW-1:0] cnt;

    assign limit_hit = (cnt == CW'(LIMIT_CYC));

    // Count page-mode time, clearing whenever the run is broken.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (!limit_hit) cnt <= cnt + CW'(1);
    end

    // R8
    limit_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_hit && run) |=> limit_hit);
endmodule

// File: rtl/psram_lane_map.sv
// Maps lane enables onto active-low byte strobes and zeroes disabled read lanes.
// Assumes lane g covers data bits 8*g+7 .. 8*g; purely combinational.
module psram_lane_map #(
    parameter int NLANE = 2
) (
    input  logic               active,
    input  logic [NLANE-1:0]   be,
    input  logic [8*NLANE-1:0] dq_in,
    output logic [NLANE-1:0]   strobe_n,
    output logic [8*NLANE-1:0] rd_masked
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // Strobe low only while an access is running on an enabled lane.
        assign strobe_n[g]          = !(active && be[g]);
        // Pass sampled data only for enabled lanes.
        assign rd_masked[8*g +: 8]  = be[g] ? dq_in[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/psram_seq.sv
// Access sequencer: accepts requests, decides page or random cycles and decodes
// the memory strobes from its registered state. Assumes T_RAND >= 3,
// T_PWRITE >= 2, T_PREAD >= 1 and T_PRE >= 1 (all in clock cycles).
module psram_seq
    import psram_pkg::*;
#(
    parameter int T_RAND   = 7,
    parameter int T_PREAD  = 4,
    parameter int T_PWRITE = 3,
    parameter int T_PRE    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_ok,
    input  logic                burst_hit,
    output logic                burst_run,
    input  logic                req_valid,
    output logic                req_ready,
    input  psram_req_t          req_in,
    output logic                rsp_valid,
    output logic [PS_DW-1:0]    rsp_rdata,
    output logic                acc_active,
    output logic [PS_NLANE-1:0] acc_be,
    output logic [PS_AW-1:0]    mem_addr,
    output logic                cs_n,
    output logic                oe_n,
    output logic                we_n,
    output logic [PS_DW-1:0]    dq_out,
    output logic                dq_oe,
    input  logic [PS_DW-1:0]    rd_masked
);
    localparam int T_PG_RD = T_PRE + T_PREAD;
    localparam int T_PG_WR = T_PRE + T_PWRITE;
    localparam int M1      = (T_RAND > T_PG_RD) ? T_RAND : T_PG_RD;
    localparam int M2      = (M1 > T_PG_WR) ? M1 : T_PG_WR;
    localparam int MAXL    = (M2 > T_PRE) ? M2 : T_PRE;
    localparam int CW      = $clog2(MAXL + 1);

    seq_state_t       state;
    logic [CW-1:0]    cnt;
    psram_req_t       req_q;
    logic             page_q;
    logic             pend_q;
    logic             rsp_q;
    logic [PS_DW-1:0] rdata_q;

    logic          hit, accept, acc_last, in_acc, we_win;
    logic [CW-1:0] last_idx;

    // Acceptance and page-hit decision for the incoming request.
    always_comb begin
        req_ready = (state == S_IDLE) || (state == S_OPEN && !burst_hit);
        accept    = req_valid && req_ready;
        hit       = (req_in.wr == req_q.wr) &&
                    (req_in.addr[PS_AW-1:PS_OFS] == req_q.addr[PS_AW-1:PS_OFS]);
        last_idx  = page_q ? (req_q.wr ? CW'(T_PG_WR - 1) : CW'(T_PG_RD - 1))
                           : CW'(T_RAND - 1);
        in_acc    = (state == S_ACC);
        acc_last  = in_acc && (cnt == last_idx);
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_PWRUP;
            cnt    <= '0;
            req_q  <= '0;
            page_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            case (state)
                S_PWRUP: if (pwr_ok) state <= S_IDLE;
                S_IDLE: if (accept) begin
                    req_q  <= req_in;
                    page_q <= 1'b0;
                    cnt    <= '0;
                    state  <= S_ACC;
                end
                S_OPEN: if (burst_hit) begin
                    pend_q <= 1'b0;
                    cnt    <= '0;
                    state  <= S_GAP;
                end else if (accept) begin
                    req_q <= req_in;
                    cnt   <= '0;
                    if (hit) begin
                        page_q <= 1'b1;
                        state  <= S_ACC;
                    end else begin
                        page_q <= 1'b0;
                        pend_q <= 1'b1;
                        state  <= S_GAP;
                    end
                end
                S_GAP: if (cnt == CW'(T_PRE - 1)) begin
                    cnt    <= '0;
                    page_q <= 1'b0;
                    state  <= pend_q ? S_ACC : S_IDLE;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                S_ACC: if (acc_last) begin
                    cnt   <= '0;
                    state <= S_OPEN;
                end else begin
                    cnt <= cnt + CW'(1);
                end
                default: state <= S_PWRUP;
            endcase
        end
    end

    // Capture read data on the final access cycle and pulse the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rsp_q <= acc_last && !req_q.wr;
            if (acc_last && !req_q.wr) rdata_q <= rd_masked;
        end
    end

    // Decode memory strobes and bus drive from the registered state.
    always_comb begin
        if (page_q) we_win = (cnt >= CW'(T_PRE)) && (cnt <= CW'(T_PG_WR - 2));
        else        we_win = (cnt >= CW'(1)) && (cnt <= CW'(T_RAND - 2));
        cs_n       = !(in_acc || state == S_OPEN);
        oe_n       = !(in_acc && !req_q.wr);
        we_n       = !(in_acc && req_q.wr && we_win);
        dq_oe      = in_acc && req_q.wr && (page_q || cnt != '0);
        burst_run  = (state == S_OPEN) || (in_acc && page_q);
        acc_active = in_acc;
        acc_be     = req_q.be;
        mem_addr   = req_q.addr;
        dq_out     = req_q.wdata;
        rsp_valid  = rsp_q;
        rsp_rdata  = rdata_q;
    end

    // R9
    bus_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (oe_n && $past(oe_n)));
    // R10
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acc && $past(state) == S_ACC && $past(cnt) != $past(last_idx)) |-> $stable(mem_addr));
    // R8
    limit_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPEN && burst_hit) |=> cs_n);
    // R7
    miss_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPEN && !burst_hit && accept && !hit) |=> cs_n);
endmodule

// File: rtl/psram_page_ctrl.sv
// Top of the page-mode pseudo-SRAM controller: joins the power-up timer, the
// page-burst guard, the access sequencer and the byte-lane mapper.
// Assumes all timing parameters are clock cycles already rounded up.
module psram_page_ctrl
    import psram_pkg::*;
#(
    parameter int T_RAND_CYC   = 7,
    parameter int T_PREAD_CYC  = 4,
    parameter int T_PWRITE_CYC = 3,
    parameter int T_PRE_CYC    = 1,
    parameter int PWRUP_CYC    = 10000,
    parameter int BURST_CYC    = 1500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [19:0] req_addr,
    input  logic [15:0] req_wdata,
    input  logic [1:0]  req_be,
    output logic        rsp_valid,
    output logic [15:0] rsp_rdata,
    output logic [19:0] mem_addr,
    output logic        mem_cs_n,
    output logic        mem_oe_n,
    output logic        mem_we_n,
    output logic        mem_ub_n,
    output logic        mem_lb_n,
    output logic        mem_pd_n,
    output logic [15:0] mem_dq_out,
    output logic        mem_dq_oe,
    input  logic [15:0] mem_dq_in
);
    logic                pwr_ok, burst_hit, burst_run, acc_active;
    logic [PS_NLANE-1:0] acc_be, strobe_n;
    logic [PS_DW-1:0]    rd_masked;
    psram_req_t          req_in;

    // Bundle the request fields for the sequencer.
    always_comb begin
        req_in.wr    = req_write;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
        req_in.be    = req_be;
    end

    assign mem_pd_n = 1'b1;
    assign mem_ub_n = strobe_n[1];
    assign mem_lb_n = strobe_n[0];

    psram_pwrup_timer #(.HOLD_CYC(PWRUP_CYC)) u_pwrup (
        .clk(clk), .rst_n(rst_n), .hold_done(pwr_ok)
    );

    psram_burst_guard #(.LIMIT_CYC(BURST_CYC)) u_burst (
        .clk(clk), .rst_n(rst_n), .run(burst_run), .limit_hit(burst_hit)
    );

    psram_seq #(
        .T_RAND(T_RAND_CYC), .T_PREAD(T_PREAD_CYC),
        .T_PWRITE(T_PWRITE_CYC), .T_PRE(T_PRE_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .burst_hit(burst_hit),
        .burst_run(burst_run), .req_valid(req_valid), .req_ready(req_ready),
        .req_in(req_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .acc_active(acc_active), .acc_be(acc_be), .mem_addr(mem_addr),
        .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
        .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .rd_masked(rd_masked)
    );

    psram_lane_map #(.NLANE(PS_NLANE)) u_lanes (
        .active(acc_active), .be(acc_be), .dq_in(mem_dq_in),
        .strobe_n(strobe_n), .rd_masked(rd_masked)
    );

    // R1
    pwrup_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (mem_cs_n && !req_ready));
    // R4
    write_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));
endmodule

// File: tb/psram_page_ctrl_test.sv
// Bench: pin-level memory model, directed corner cases, then seeded random traffic.
module psram_page_ctrl_test;
    localparam int PWR = 50, LIM = 40, TR = 7, TPR = 4, TPW = 3, TPC = 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_dq_out;
    logic [15:0] mem_dq_in = 16'hFFFF;
    logic [19:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_pd_n, mem_dq_oe;

    psram_page_ctrl #(.T_RAND_CYC(TR), .T_PREAD_CYC(TPR), .T_PWRITE_CYC(TPW),
                      .T_PRE_CYC(TPC), .PWRUP_CYC(PWR), .BURST_CYC(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_pd_n(mem_pd_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int run_len = 0, max_run = 0, cs_hi_cnt = 0;
    int bus_err = 0, strobe_err = 0, rsp_err = 0, rsp_cnt = 0, n_reads = 0, pd_err = 0;
    logic prev_oe_n = 1'b1, prev_rsp = 1'b0;
    logic [1:0] cur_be = 2'b11;
    logic [15:0] pmem [int];
    logic [15:0] refm [int];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] init_word(input int a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] pm_rd(input int a);
        return pmem.exists(a) ? pmem[a] : init_word(a);
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return refm.exists(a) ? refm[a] : init_word(a);
    endfunction

    function automatic logic [15:0] lane_mask(input logic [15:0] d, input logic [1:0] be);
        return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Pin model and monitors, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n && !mem_we_n) begin
                logic [15:0] w;
                w = pm_rd(int'(mem_addr));
                if (!mem_dq_oe) bus_err++;
                if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
                if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
                pmem[int'(mem_addr)] = w;
            end
            if (mem_dq_oe && (!mem_oe_n || !prev_oe_n)) bus_err++;
            if (!mem_cs_n && (!mem_oe_n || !mem_we_n) &&
                (mem_ub_n != !cur_be[1] || mem_lb_n != !cur_be[0])) strobe_err++;
            if (!mem_pd_n) pd_err++;
            if (!mem_cs_n) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
            end else begin
                run_len = 0;
                cs_hi_cnt++;
            end
            if (rsp_valid) begin
                rsp_cnt++;
                if (prev_rsp) rsp_err++;
            end
            prev_rsp  = rsp_valid;
            prev_oe_n = mem_oe_n;
        end
        if (!mem_cs_n && !mem_oe_n) begin
            logic [15:0] r;
            r = pm_rd(int'(mem_addr));
            mem_dq_in = {mem_ub_n ? 8'hFF : r[15:8], mem_lb_n ? 8'hFF : r[7:0]};
        end else begin
            mem_dq_in = 16'hFFFF;
        end
    end

    // Wait (at negedges) until the controller is ready.
    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] w;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        wait_ready();
        @(posedge clk);
        cur_be = be;
        w = ref_rd(int'(a));
        if (be[0]) w[7:0]  = d[7:0];
        if (be[1]) w[15:8] = d[15:8];
        refm[int'(a)] = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [19:0] a, input logic [1:0] be, input int exp_lat,
                           input string rq, output int lat);
        int acc;
        logic [15:0] exp_d;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        wait_ready();
        @(posedge clk);
        cur_be = be;
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        n_reads++;
        while (!rsp_valid) @(negedge clk);
        lat = cyc - acc;
        exp_d = lane_mask(ref_rd(int'(a)), be);
        chk(rsp_rdata == exp_d, {rq, " read data"}, rsp_rdata, exp_d);
        if (exp_lat >= 0) chk(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat, n_lo, snap, cs_err;
        bit seen_rand;
        logic [17:0] pages [4];
        pages[0] = 18'h048D1; pages[1] = 18'h10000; pages[2] = 18'h3FFFF; pages[3] = 18'h00000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n == 1'b1 && mem_pd_n == 1'b1 && req_ready == 1'b0 && rsp_valid == 1'b0,
            "R1 reset state", {mem_cs_n, mem_pd_n, req_ready, rsp_valid}, 4'b1100);
        rst_n = 1'b1;
        n_lo = 0; cs_err = 0;
        while (!req_ready && n_lo < 10000) begin
            if (!mem_cs_n) cs_err++;
            n_lo++;
            @(negedge clk);
        end
        chk(n_lo >= PWR && n_lo <= PWR + 3, "R1 power-up hold length", n_lo, PWR);
        chk(cs_err == 0, "R1 cs held high during hold", cs_err, 0);

        // R2: first read from idle is a random cycle
        do_read(20'h12344, 2'b11, TR, "R2 random read", lat);
        // R5: same-page reads without a chip-select break
        snap = cs_hi_cnt;
        do_read(20'h12345, 2'b11, TPC + TPR, "R5 page read w1", lat);
        do_read(20'h12347, 2'b10, TPC + TPR, "R5 page read w3", lat);
        do_read(20'h12346, 2'b01, TPC + TPR, "R5 page read w2", lat);
        chk(cs_hi_cnt == snap, "R5 cs stays low", cs_hi_cnt - snap, 0);
        // R7: page miss
        snap = cs_hi_cnt;
        do_read(20'h40000, 2'b11, TPC + TR, "R7 page miss read", lat);
        chk(cs_hi_cnt - snap == TPC, "R7 precharge gap length", cs_hi_cnt - snap, TPC);
        // R6: same-page writes after a direction change
        do_write(20'h40001, 16'h1111, 2'b11);
        @(negedge clk);
        wait_ready();
        snap = cs_hi_cnt;
        do_write(20'h40002, 16'h2222, 2'b11);
        do_write(20'h40003, 16'hABCD, 2'b10);
        wait_ready();
        chk(cs_hi_cnt == snap, "R6 page writes keep cs low", cs_hi_cnt - snap, 0);
        // R4 and R3: read back merged words; direction change gives random latency
        do_read(20'h40002, 2'b11, TPC + TR, "R4 write readback", lat);
        do_read(20'h40003, 2'b11, TPC + TPR, "R3 upper-lane write merge", lat);
        do_read(20'h40001, 2'b01, TPC + TPR, "R3 disabled lane reads zero", lat);
        // R8: long same-page stream forces a close and a random cycle
        seen_rand = 1'b0;
        for (int i = 0; i < 24; i++) begin
            do_read({18'h048D1, 2'(i)}, 2'b11, -1, "R8 stream read", lat);
            if (i > 0 && lat == TR) seen_rand = 1'b1;
        end
        chk(seen_rand, "R8 forced close seen", seen_rand, 1);
        chk(max_run > LIM, "R8 page run exceeded limit window", max_run, LIM);
        chk(max_run <= TR + LIM + TPC + TPR + 2, "R8 cs low run bounded", max_run,
            TR + LIM + TPC + TPR + 2);
        // Seeded random mix (R3, R4)
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            logic [1:0]  be;
            a  = {pages[$urandom_range(0, 3)], 2'($urandom_range(0, 3))};
            be = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 1) == 1) do_write(a, 16'($urandom), be);
            else do_read(a, be, -1, "R4 random read", lat);
        end
        @(negedge clk);
        wait_ready();
        repeat (3) @(negedge clk);
        chk(bus_err == 0, "R9 bus drive only after output enable high", bus_err, 0);
        chk(strobe_err == 0, "R3 byte strobe mapping", strobe_err, 0);
        chk(pd_err == 0, "R1 power-down pin held inactive", pd_err, 0);
        chk(rsp_err == 0, "R10 single-cycle response", rsp_err, 0);
        chk(rsp_cnt == n_reads, "R10 one response per read", rsp_cnt, n_reads);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule